// File: doc/BRIEF.md
# Stalling Decode Stage Controller

This block sits between an instruction fetch group and a rename port in a multi-threaded pipeline. It carries opaque instruction tokens (a sequence number tagged with a thread number) and does not interpret them. Each cycle it forwards up to a fixed number of tokens to rename. Every thread is driven by its own five-state status machine (idle, running, blocked, unblocking, squashing), and the threads are served in ascending thread number. All threads draw from the same pool of output slots within a cycle.

Three downstream sources (rename, execute, commit) can stall a thread with set and clear pulses. While a thread is stalled, or when it has more tokens than there are free output slots, its tokens are parked in a per-thread skid buffer. The depth of that buffer is fetch latency times fetch width plus decode width. The block pulses a block line back to fetch when a thread starts holding tokens. It pulses an unblock line only once the skid buffer has been fully drained. A commit squash flushes the thread and takes priority over everything else. A reorder-buffer squash indication keeps the thread quiet while it is asserted.

Top module: `dcd_stage_ctrl`

## Requirements
- R1: After reset every thread is idle with all stall flags clear; with no fetch input, out_vld, fetch_block and fetch_unblock are all zero, and an idle thread forwards tokens like a running one.
- R2: Fetch slot s is valid when s < fe_cnt. Its thread is fe_tid[s*TID_W +: TID_W] and its sequence number is fe_seq[s*SEQ_W +: SEQ_W]. Forwarded tokens appear combinationally in the same cycle and fill out_vld from bit 0 upward with no gaps. The threads are taken in ascending number, each thread's tokens in fetch slot order, and out_tid reports the thread for each slot.
- R3: A fetch slot whose fe_squashed bit is set is dropped and takes no output slot.
- R4: Tokens that a running thread cannot place in the free slots go to its skid buffer, and fetch_block for that thread pulses. The buffer holds FETCH_LAT*FETCH_W+DEC_W tokens and the request never exceeds that.
- R5: Each source keeps a per-thread stall flag. A set pulse raises it and a clear pulse lowers it, and a clear wins over a set in the same cycle. While any flag is raised after that cycle's pulses, the thread forwards nothing and parks its incoming tokens. fetch_block pulses only on entry to the blocked state.
- R6: In the first cycle with no stall, a blocked thread becomes unblocking. From then on it forwards skid tokens oldest first and appends new arrivals behind them. fetch_unblock pulses, and the thread runs, in the cycle the buffer becomes empty. A blocked thread with an empty buffer resumes at once.
- R7: A commit squash discards the thread's skid and incoming tokens and forwards nothing. It pulses fetch_unblock if the thread was blocked or unblocking. In the next cycle without a squash the thread runs.
- R8: While rob_squashing is high, and there is no commit squash, the thread forwards nothing, drops its incoming tokens and sends no pulse. It runs again in the next cycle.
- R9: fetch_block and fetch_unblock are never high together for one thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_cnt | input | FC_W | Number of valid fetch slots |
| fe_tid | input | FETCH_W*TID_W | Thread number per fetch slot |
| fe_seq | input | FETCH_W*SEQ_W | Sequence number per fetch slot |
| fe_squashed | input | FETCH_W | Slot already squashed |
| ren_stall_set | input | NUM_THR | Rename stall set pulse per thread |
| ren_stall_clr | input | NUM_THR | Rename stall clear pulse per thread |
| exe_stall_set | input | NUM_THR | Execute stall set pulse per thread |
| exe_stall_clr | input | NUM_THR | Execute stall clear pulse per thread |
| cmt_stall_set | input | NUM_THR | Commit stall set pulse per thread |
| cmt_stall_clr | input | NUM_THR | Commit stall clear pulse per thread |
| cmt_squash | input | NUM_THR | Commit squash per thread |
| rob_squashing | input | NUM_THR | Reorder buffer still squashing per thread |
| out_vld | output | DEC_W | Output slot valid |
| out_seq | output | DEC_W*SEQ_W | Output slot sequence number |
| out_tid | output | DEC_W*TID_W | Output slot thread number |
| fetch_block | output | NUM_THR | Block pulse to fetch |
| fetch_unblock | output | NUM_THR | Unblock pulse to fetch |

## Verification
Several properties are checked on every cycle. The skid request never goes beyond the buffer depth. Block and unblock are never high together. A stalled, squashed or reorder-squashing thread takes no output slot. Output slots are always packed from the bottom. A block pulse is always followed by the blocked state, and a non-squash unblock pulse by an empty buffer. The token ordering itself can only be shown by the bench's scenarios. This covers skid contents draining oldest first ahead of newer arrivals, slot sharing between threads, and the exact cycle of each pulse. It also covers what survives a squash.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    TS_IDLE  = 3'd0,
    TS_RUN   = 3'd1,
    TS_BLK   = 3'd2,
    TS_UNBLK = 3'd3,
    TS_SQ    = 3'd4
  } thr_state_e;
endpackage

// File: rtl/dcd_stall_track.sv
module dcd_stall_track #(
  parameter int NUM_THR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] ren_set,
  input  logic [NUM_THR-1:0] ren_clr,
  input  logic [NUM_THR-1:0] exe_set,
  input  logic [NUM_THR-1:0] exe_clr,
  input  logic [NUM_THR-1:0] cmt_set,
  input  logic [NUM_THR-1:0] cmt_clr,
  output logic [NUM_THR-1:0] stalled
);
  localparam int NSRC = 3;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [NSRC-1:0] flag_q, flag_d, set_v, clr_v;

    assign set_v = {cmt_set[t], exe_set[t], ren_set[t]};
    assign clr_v = {cmt_clr[t], exe_clr[t], ren_clr[t]};

    always_comb begin
      flag_d = (flag_q | set_v) & ~clr_v;
    end

    assign stalled[t] = |flag_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/dcd_lane.sv
module dcd_lane
  import dcd_pkg::*;
#(
  parameter int ID      = 0,
  parameter int FETCH_W = 4,
  parameter int DEC_W   = 2,
  parameter int SEQ_W   = 8,
  parameter int TID_W   = 1,
  parameter int DEPTH   = 6,
  parameter int FC_W    = 3,
  parameter int SC_W    = 2,
  parameter int BC_W    = 3,
  parameter int RQ_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stalled,
  input  logic                     squash,
  input  logic                     rob_sq,
  input  logic [FC_W-1:0]          fe_cnt,
  input  logic [FETCH_W*TID_W-1:0] fe_tid,
  input  logic [FETCH_W*SEQ_W-1:0] fe_seq,
  input  logic [FETCH_W-1:0]       fe_sq,
  input  logic [SC_W-1:0]          slot_base,
  output logic [SC_W-1:0]          slot_next,
  output logic [DEC_W-1:0]         o_vld,
  output logic [DEC_W*SEQ_W-1:0]   o_seq,
  output logic                     blk_pulse,
  output logic                     unb_pulse,
  output logic [2:0]               st_o,
  output logic [BC_W-1:0]          cnt_o,
  output logic [RQ_W-1:0]          req_o
);
  localparam int BI_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IL_W = (FETCH_W > 1) ? $clog2(FETCH_W) : 1;

  thr_state_e st_q, st_d, nxt;
  logic [BC_W-1:0]  cnt_q, cnt_d;
  logic [SEQ_W-1:0] buf_q [DEPTH];
  logic [SEQ_W-1:0] buf_d [DEPTH];
  logic [SEQ_W-1:0] inc_list [FETCH_W];
  logic             buf_we, from_skid, flush;
  int               inc_n, base, avail, cnt, pop_n, emit_n, app_off, app_n, rem, k, tot;

  always_comb begin
    // Gather this thread's live tokens in fetch order
    inc_n = 0;
    for (int s = 0; s < FETCH_W; s++) inc_list[s] = '0;
    for (int s = 0; s < FETCH_W; s++) begin
      if (s < int'(fe_cnt) && fe_tid[s*TID_W +: TID_W] == TID_W'(ID) && !fe_sq[s]) begin
        inc_list[IL_W'(inc_n)] = fe_seq[s*SEQ_W +: SEQ_W];
        inc_n = inc_n + 1;
      end
    end

    base      = int'(slot_base);
    avail     = DEC_W - base;
    cnt       = int'(cnt_q);
    st_d      = st_q;
    nxt       = st_q;
    blk_pulse = 1'b0;
    unb_pulse = 1'b0;
    flush     = 1'b0;
    from_skid = 1'b0;
    pop_n     = 0;
    emit_n    = 0;
    app_off   = 0;
    app_n     = 0;

    if (squash) begin
      st_d      = TS_SQ;
      flush     = 1'b1;
      unb_pulse = (st_q == TS_BLK) || (st_q == TS_UNBLK);
    end else if (rob_sq) begin
      st_d = TS_SQ;
    end else if (stalled) begin
      app_n = inc_n;
      if (st_q != TS_BLK) begin
        st_d      = TS_BLK;
        blk_pulse = 1'b1;
      end
    end else begin
      if (st_q == TS_BLK) begin
        if (cnt == 0) begin
          nxt       = TS_RUN;
          unb_pulse = 1'b1;
        end else begin
          nxt = TS_UNBLK;
        end
      end else if (st_q == TS_SQ) begin
        nxt = TS_RUN;
      end

      if (nxt == TS_RUN || nxt == TS_IDLE) begin
        emit_n  = (avail < inc_n) ? avail : inc_n;
        app_off = emit_n;
        app_n   = inc_n - emit_n;
        if (app_n > 0) begin
          if (unb_pulse) unb_pulse = 1'b0;   // fetch was never released
          else           blk_pulse = 1'b1;
          nxt = TS_BLK;
        end
      end else if (nxt == TS_UNBLK) begin
        pop_n     = (avail < cnt) ? avail : cnt;
        emit_n    = pop_n;
        from_skid = 1'b1;
        app_n     = inc_n;
        if (cnt - pop_n + inc_n == 0) begin
          nxt       = TS_RUN;
          unb_pulse = 1'b1;
        end
      end
      st_d = nxt;
    end

    rem = flush ? 0 : (cnt - pop_n);
    if (flush) app_n = 0;
    tot    = rem + app_n;
    req_o  = RQ_W'(tot);
    cnt_d  = BC_W'((tot > DEPTH) ? DEPTH : tot);
    buf_we = (pop_n != 0) || (app_n != 0);

    for (int i = 0; i < DEPTH; i++) begin
      buf_d[i] = buf_q[i];
      if (i < rem) begin
        if (i + pop_n < DEPTH) buf_d[i] = buf_q[BI_W'(i + pop_n)];
      end else if ((i - rem) < app_n && (app_off + i - rem) < FETCH_W) begin
        buf_d[i] = inc_list[IL_W'(app_off + i - rem)];
      end
    end

    o_vld = '0;
    o_seq = '0;
    for (int a = 0; a < DEC_W; a++) begin
      k = a - base;
      if (k >= 0 && k < emit_n) begin
        o_vld[a] = 1'b1;
        if (from_skid) begin
          if (k < DEPTH) o_seq[a*SEQ_W +: SEQ_W] = buf_q[BI_W'(k)];
        end else begin
          if (k < FETCH_W) o_seq[a*SEQ_W +: SEQ_W] = inc_list[IL_W'(k)];
        end
      end
    end

    slot_next = SC_W'(base + emit_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= buf_d[i];
    end
  end

  assign st_o  = st_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dcd_stage_ctrl.sv
module dcd_stage_ctrl #(
  parameter int NUM_THR   = 2,
  parameter int FETCH_W   = 4,
  parameter int DEC_W     = 2,
  parameter int FETCH_LAT = 1,
  parameter int SEQ_W     = 8,
  localparam int TID_W      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int FC_W       = $clog2(FETCH_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FC_W-1:0]          fe_cnt,
  input  logic [FETCH_W*TID_W-1:0] fe_tid,
  input  logic [FETCH_W*SEQ_W-1:0] fe_seq,
  input  logic [FETCH_W-1:0]       fe_squashed,
  input  logic [NUM_THR-1:0]       ren_stall_set,
  input  logic [NUM_THR-1:0]       ren_stall_clr,
  input  logic [NUM_THR-1:0]       exe_stall_set,
  input  logic [NUM_THR-1:0]       exe_stall_clr,
  input  logic [NUM_THR-1:0]       cmt_stall_set,
  input  logic [NUM_THR-1:0]       cmt_stall_clr,
  input  logic [NUM_THR-1:0]       cmt_squash,
  input  logic [NUM_THR-1:0]       rob_squashing,
  output logic [DEC_W-1:0]         out_vld,
  output logic [DEC_W*SEQ_W-1:0]   out_seq,
  output logic [DEC_W*TID_W-1:0]   out_tid,
  output logic [NUM_THR-1:0]       fetch_block,
  output logic [NUM_THR-1:0]       fetch_unblock
);
  localparam int SKID_DEPTH = FETCH_LAT * FETCH_W + DEC_W;
  localparam int SC_W       = $clog2(DEC_W + 1);
  localparam int BC_W       = $clog2(SKID_DEPTH + 1);
  localparam int RQ_W       = $clog2(SKID_DEPTH + FETCH_W + 1) + 1;

  logic [NUM_THR-1:0]             stalled_v;
  logic [(NUM_THR+1)*SC_W-1:0]    slot_chain;
  logic [NUM_THR*DEC_W-1:0]       lane_vld_v;
  logic [NUM_THR*DEC_W*SEQ_W-1:0] lane_seq_v;
  logic [NUM_THR-1:0]             used_v;
  logic [NUM_THR*3-1:0]           state_v;
  logic [NUM_THR*BC_W-1:0]        cnt_v;
  logic [NUM_THR*RQ_W-1:0]        req_v;

  dcd_stall_track #(.NUM_THR(NUM_THR)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .ren_set (ren_stall_set),
    .ren_clr (ren_stall_clr),
    .exe_set (exe_stall_set),
    .exe_clr (exe_stall_clr),
    .cmt_set (cmt_stall_set),
    .cmt_clr (cmt_stall_clr),
    .stalled (stalled_v)
  );

  assign slot_chain[SC_W-1:0] = '0;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_lane
    dcd_lane #(
      .ID(t), .FETCH_W(FETCH_W), .DEC_W(DEC_W), .SEQ_W(SEQ_W), .TID_W(TID_W),
      .DEPTH(SKID_DEPTH), .FC_W(FC_W), .SC_W(SC_W), .BC_W(BC_W), .RQ_W(RQ_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .stalled   (stalled_v[t]),
      .squash    (cmt_squash[t]),
      .rob_sq    (rob_squashing[t]),
      .fe_cnt    (fe_cnt),
      .fe_tid    (fe_tid),
      .fe_seq    (fe_seq),
      .fe_sq     (fe_squashed),
      .slot_base (slot_chain[t*SC_W +: SC_W]),
      .slot_next (slot_chain[(t+1)*SC_W +: SC_W]),
      .o_vld     (lane_vld_v[t*DEC_W +: DEC_W]),
      .o_seq     (lane_seq_v[t*DEC_W*SEQ_W +: DEC_W*SEQ_W]),
      .blk_pulse (fetch_block[t]),
      .unb_pulse (fetch_unblock[t]),
      .st_o      (state_v[t*3 +: 3]),
      .cnt_o     (cnt_v[t*BC_W +: BC_W]),
      .req_o     (req_v[t*RQ_W +: RQ_W])
    );
    assign used_v[t] = |lane_vld_v[t*DEC_W +: DEC_W];
  end

  always_comb begin
    out_vld = '0;
    out_seq = '0;
    out_tid = '0;
    for (int a = 0; a < DEC_W; a++) begin
      for (int t = 0; t < NUM_THR; t++) begin
        if (lane_vld_v[t*DEC_W + a]) begin
          out_vld[a]                  = 1'b1;
          out_seq[a*SEQ_W +: SEQ_W]   = lane_seq_v[(t*DEC_W + a)*SEQ_W +: SEQ_W];
          out_tid[a*TID_W +: TID_W]   = TID_W'(t);
        end
      end
    end
  end
endmodule

// File: rtl/dcd_stage_chk.sv
module dcd_stage_chk
  import dcd_pkg::*;
#(
  parameter int NUM_THR = 2,
  parameter int DEC_W   = 2,
  parameter int DEPTH   = 6,
  parameter int BC_W    = 3,
  parameter int RQ_W    = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_THR-1:0]      cmt_squash,
  input logic [NUM_THR-1:0]      rob_squashing,
  input logic [NUM_THR-1:0]      fetch_block,
  input logic [NUM_THR-1:0]      fetch_unblock,
  input logic [DEC_W-1:0]        out_vld,
  input logic [NUM_THR-1:0]      stalled_v,
  input logic [NUM_THR-1:0]      used_v,
  input logic [NUM_THR*3-1:0]    state_v,
  input logic [NUM_THR*BC_W-1:0] cnt_v,
  input logic [NUM_THR*RQ_W-1:0] req_v
);
  a_r2_packed_slots: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld & (out_vld + 1'b1)) == '0));

  for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(req_v[t*RQ_W +: RQ_W]) <= DEPTH);
    a_r4_block_enters: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_block[t] |=> (state_v[t*3 +: 3] == 3'(TS_BLK)));
    a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_block[t] && fetch_unblock[t]));
    a_r5_stall_silent: assert property (@(posedge clk) disable iff (!rst_n)
      stalled_v[t] |-> !used_v[t]);
    a_r7_squash_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[t] |-> (!used_v[t] && !fetch_block[t]));
    a_r8_rob_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_squashing[t] && !cmt_squash[t]) |-> (!used_v[t] && !fetch_block[t] && !fetch_unblock[t]));
    a_r6_unblock_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_unblock[t] && !cmt_squash[t]) |=> (cnt_v[t*BC_W +: BC_W] == '0));
  end
endmodule

bind dcd_stage_ctrl dcd_stage_chk #(
  .NUM_THR(NUM_THR), .DEC_W(DEC_W), .DEPTH(SKID_DEPTH), .BC_W(BC_W), .RQ_W(RQ_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmt_squash    (cmt_squash),
  .rob_squashing (rob_squashing),
  .fetch_block   (fetch_block),
  .fetch_unblock (fetch_unblock),
  .out_vld       (out_vld),
  .stalled_v     (stalled_v),
  .used_v        (used_v),
  .state_v       (state_v),
  .cnt_v         (cnt_v),
  .req_v         (req_v)
);

// File: tb/dcd_stage_ctrl_tb_top.sv
module dcd_stage_ctrl_tb_top;
  localparam int NT = 2;
  localparam int FW = 4;
  localparam int DW = 2;
  localparam int SW = 8;
  localparam int TW = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [2:0]       fcnt;
  logic [FW*TW-1:0] ftid;
  logic [FW*SW-1:0] fseq;
  logic [FW-1:0]    fsq;
  logic [NT-1:0]    rs, rc, es, ec, cs, cc, csq, rob;
  logic [DW-1:0]    ovld;
  logic [DW*SW-1:0] oseq;
  logic [DW*TW-1:0] otid;
  logic [NT-1:0]    fblk, funb;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R1";
  int    exp_tid[$];
  int    exp_seq[$];

  dcd_stage_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fe_cnt(fcnt), .fe_tid(ftid), .fe_seq(fseq),
    .fe_squashed(fsq), .ren_stall_set(rs), .ren_stall_clr(rc),
    .exe_stall_set(es), .exe_stall_clr(ec), .cmt_stall_set(cs),
    .cmt_stall_clr(cc), .cmt_squash(csq), .rob_squashing(rob),
    .out_vld(ovld), .out_seq(oseq), .out_tid(otid),
    .fetch_block(fblk), .fetch_unblock(funb)
  );

  task automatic clr_in();
    fcnt = '0; ftid = '0; fseq = '0; fsq = '0;
    rs = '0; rc = '0; es = '0; ec = '0; cs = '0; cc = '0; csq = '0; rob = '0;
  endtask

  task automatic put(input int tid, input int seq, input bit sq);
    ftid[int'(fcnt)*TW +: TW] = TW'(tid);
    fseq[int'(fcnt)*SW +: SW] = SW'(seq);
    fsq[int'(fcnt)]           = sq;
    fcnt = fcnt + 3'd1;
  endtask

  task automatic exp_tok(input int tid, input int seq);
    exp_tid.push_back(tid);
    exp_seq.push_back(seq);
  endtask

  // Monitor: pops the scoreboard for every forwarded token
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int a = 0; a < DW; a++) begin
        if (ovld[a]) begin
          checks++;
          if (exp_seq.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected token tid=%0d seq=%0d, expected none", tag,
                     otid[a*TW +: TW], oseq[a*SW +: SW]);
          end else begin
            int et, es2;
            et  = exp_tid.pop_front();
            es2 = exp_seq.pop_front();
            if (int'(otid[a*TW +: TW]) != et || int'(oseq[a*SW +: SW]) != es2) begin
              fails++;
              $display("FAIL %s: slot %0d got tid=%0d seq=%0d, expected tid=%0d seq=%0d",
                       tag, a, otid[a*TW +: TW], oseq[a*SW +: SW], et, es2);
            end
          end
        end
      end
    end
  end

  task automatic step(input string t, input logic [NT-1:0] eblk, input logic [NT-1:0] eunb);
    tag = t;
    @(negedge clk);
    #1;
    checks++;
    if (fblk !== eblk) begin
      fails++;
      $display("FAIL %s: fetch_block=%b, expected %b", t, fblk, eblk);
    end
    checks++;
    if (funb !== eunb) begin
      fails++;
      $display("FAIL %s: fetch_unblock=%b, expected %b", t, funb, eunb);
    end
    checks++;
    if (exp_seq.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d tokens missing, expected 0 left", t, exp_seq.size());
      exp_seq.delete();
      exp_tid.delete();
    end
    @(posedge clk);
    #1;
    clr_in();
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: quiet after reset
    checks++;
    if (ovld !== '0 || fblk !== '0 || funb !== '0) begin
      fails++;
      $display("FAIL R1: vld=%b blk=%b unb=%b, expected all zero", ovld, fblk, funb);
    end
    step("R1", 2'b00, 2'b00);

    // R2: idle threads forward, ascending thread order
    put(0, 10, 0); put(1, 20, 0); exp_tok(0, 10); exp_tok(1, 20);
    step("R2", 2'b00, 2'b00);
    put(1, 21, 0); put(0, 11, 0); exp_tok(0, 11); exp_tok(1, 21);
    step("R2", 2'b00, 2'b00);

    // R3: squashed slot takes no output slot
    put(0, 30, 1); put(0, 31, 0); put(0, 32, 0); exp_tok(0, 31); exp_tok(0, 32);
    step("R3", 2'b00, 2'b00);

    // R4: leftover blocks and is parked
    put(0, 40, 0); put(0, 41, 0); put(0, 42, 0); exp_tok(0, 40); exp_tok(0, 41);
    step("R4", 2'b01, 2'b00);
    // R6: drain skid first, new arrival appended, other thread shares slots
    put(0, 43, 0); put(1, 50, 0); exp_tok(0, 42); exp_tok(1, 50);
    step("R6", 2'b00, 2'b00);
    exp_tok(0, 43);
    step("R6", 2'b00, 2'b01);
    put(0, 44, 0); exp_tok(0, 44);
    step("R6", 2'b00, 2'b00);

    // R5: execute stall on thread 0
    es[0] = 1'b1; put(0, 60, 0); put(1, 70, 0); exp_tok(1, 70);
    step("R5", 2'b01, 2'b00);
    put(0, 61, 0);
    step("R5", 2'b00, 2'b00);
    ec[0] = 1'b1; put(0, 62, 0); exp_tok(0, 60); exp_tok(0, 61);
    step("R6", 2'b00, 2'b00);
    exp_tok(0, 62);
    step("R6", 2'b00, 2'b01);

    // R5: set and clear together leave no stall
    cs[1] = 1'b1; cc[1] = 1'b1; put(1, 71, 0); exp_tok(1, 71);
    step("R5", 2'b00, 2'b00);
    // R5: two sources, one cleared, still stalled
    rs[1] = 1'b1; cs[1] = 1'b1; put(1, 72, 0);
    step("R5", 2'b10, 2'b00);
    rc[1] = 1'b1; put(1, 73, 0);
    step("R5", 2'b00, 2'b00);
    cc[1] = 1'b1; exp_tok(1, 72); exp_tok(1, 73);
    step("R6", 2'b00, 2'b10);

    // R7: squash of a blocked thread
    rs[0] = 1'b1; put(0, 80, 0); put(0, 81, 0);
    step("R7", 2'b01, 2'b00);
    csq[0] = 1'b1; rc[0] = 1'b1; put(0, 82, 0); put(1, 90, 0); exp_tok(1, 90);
    step("R7", 2'b00, 2'b01);
    put(0, 83, 0); exp_tok(0, 83);
    step("R7", 2'b00, 2'b00);
    // R7: squash of a running thread sends no pulse
    csq[1] = 1'b1; put(1, 91, 0); put(0, 84, 0); exp_tok(0, 84);
    step("R7", 2'b00, 2'b00);

    // R8: reorder-buffer squashing holds the thread quiet
    rob[1] = 1'b1; put(1, 92, 0);
    step("R8", 2'b00, 2'b00);
    put(1, 93, 0); exp_tok(1, 93);
    step("R8", 2'b00, 2'b00);

    // R4: fill the skid buffer to its full depth of 6
    rs[0] = 1'b1;
    put(0, 110, 0); put(0, 111, 0); put(0, 112, 0); put(0, 113, 0);
    step("R4", 2'b01, 2'b00);
    put(0, 114, 0); put(0, 115, 0);
    step("R4", 2'b00, 2'b00);
    rc[0] = 1'b1; exp_tok(0, 110); exp_tok(0, 111);
    step("R4", 2'b00, 2'b00);
    exp_tok(0, 112); exp_tok(0, 113);
    step("R4", 2'b00, 2'b00);
    exp_tok(0, 114); exp_tok(0, 115);
    step("R4", 2'b00, 2'b01);

    // R2/R4: slot sharing leaves thread 1 a leftover
    put(0, 120, 0); put(1, 121, 0); put(1, 122, 0); exp_tok(0, 120); exp_tok(1, 121);
    step("R2", 2'b10, 2'b00);
    exp_tok(1, 122);
    step("R6", 2'b00, 2'b10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule